// File: doc/BRIEF.md
# AES-128 Next Round Key Generator

This block derives the following 128-bit round key of the AES-128 key schedule from the current round key and a round number. The current key arrives as four 32-bit words, word 0 in bits 31:0 and word 3 in bits 127:96. The bytes of each word are ordered so that the byte listed first in the usual hex notation of a key sits in the lowest byte lane. The round number comes from a 5-bit immediate field. One key step is accepted per cycle when the valid strobe is high. The result appears in an output register one clock later, with its own valid flag.

The round number is folded into the legal range before use. The block then picks the round constant and builds a temporary word from word 3 of the current key. This word is rotated, passed through the forward S-box and mixed with the constant. The four new words are produced as a chain of XORs. The S-box and the round constants are computed arithmetically in GF(2^8) and are not stored as tables.

Top module: `aes_ks_step`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and key_o is all zeros.
- R2: valid_o is high in exactly the cycle after a cycle in which valid_i was sampled high, and low otherwise.
- R3: Bit 4 of imm_i has no effect on the result. Only imm_i[3:0] selects the round.
- R4: If the value n = imm_i[3:0] is in 1..10, the round is n. Otherwise the round is n with bit 3 inverted, so 0 maps to 8, 11 to 3 and 15 to 7.
- R5: The round constant for rounds 1 to 10 is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36 (hex). It is XORed into bits 7:0 of the temporary word.
- R6: The temporary word is key word 3 (bits 127:96) rotated right by 8 bits. Each of its four bytes is then replaced by its forward AES S-box value, and finally the round constant is applied.
- R7: The new words are n0 = k0^t, n1 = k1^n0, n2 = k2^n1 and n3 = k3^n2. They are packed with n0 in bits 31:0 and n3 in bits 127:96.
- R8: When valid_i is low, key_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Step request strobe |
| key_i | input | 128 | Current round key, word 0 in bits 31:0 |
| imm_i | input | 5 | Round immediate; bits 3:0 are used |
| valid_o | output | 1 | Next key valid, one cycle after valid_i |
| key_o | output | 128 | Next round key |

## Verification
The hardest cases to reach are the folded immediates: 0, 11 to 15, and every value with bit 4 set. A normal key schedule never issues them. The bench therefore sweeps all 32 immediate values over several keys. It also checks that the folded values give the same key as their in-range partners. A full ten-round walk from the published AES-128 test key anchors the S-box, the rotation and the chaining against known round keys.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int N_WORDS = 4;
  localparam int KEY_W = WORD_W * N_WORDS;
  localparam int ROUND_W = 4;
  localparam int N_ROUNDS = 10;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // x^254 equals the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq, res;
    sq  = x;
    res = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      res = gf_mul(res, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  // rcon(r) = 2^(r-1) in GF(2^8)
  function automatic logic [7:0] rcon_of(input logic [ROUND_W-1:0] r);
    logic [7:0] c;
    c = 8'h01;
    for (int i = 2; i <= N_ROUNDS; i++)
      if (i <= int'(r)) c = gf_xtime(c);
    return c;
  endfunction
endpackage

// File: rtl/aes_ks_round_fold.sv
module aes_ks_round_fold
  import aes_ks_pkg::*;
#(
  parameter int IMM_W = 5
) (
  input  logic [IMM_W-1:0]   imm_i,
  output logic [ROUND_W-1:0] rnd_o,
  output logic [7:0]         rcon_o
);
  logic [ROUND_W-1:0] nib;
  logic               in_range;

  assign nib      = imm_i[ROUND_W-1:0];
  assign in_range = (nib >= ROUND_W'(1)) && (nib <= ROUND_W'(N_ROUNDS));
  assign rnd_o    = in_range ? nib : (nib ^ ROUND_W'(8));
  assign rcon_o   = rcon_of(rnd_o);
endmodule

// File: rtl/aes_ks_sub_word.sv
module aes_ks_sub_word
  import aes_ks_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int N_BYTES = WORD_W / BYTE_W;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    assign word_o[g*BYTE_W +: BYTE_W] = sbox_fwd(word_i[g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
  import aes_ks_pkg::*;
#(
  parameter int IMM_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             valid_o,
  output logic [KEY_W-1:0] key_o
);
  logic [ROUND_W-1:0] rnd_w;
  logic [7:0]         rcon_w;
  logic [WORD_W-1:0]  k3, rot_w, sub_w, temp_w;
  logic [KEY_W-1:0]   next_w;

  aes_ks_round_fold #(.IMM_W(IMM_W)) u_fold (
    .imm_i (imm_i),
    .rnd_o (rnd_w),
    .rcon_o(rcon_w)
  );

  assign k3    = key_i[(N_WORDS-1)*WORD_W +: WORD_W];
  assign rot_w = {k3[BYTE_W-1:0], k3[WORD_W-1:BYTE_W]};

  aes_ks_sub_word u_sub (
    .word_i(rot_w),
    .word_o(sub_w)
  );

  assign temp_w = sub_w ^ {{(WORD_W-8){1'b0}}, rcon_w};

  // XOR chain across the words
  assign next_w[WORD_W-1:0] = key_i[WORD_W-1:0] ^ temp_w;
  for (genvar w = 1; w < N_WORDS; w++) begin : g_chain
    assign next_w[w*WORD_W +: WORD_W] =
      key_i[w*WORD_W +: WORD_W] ^ next_w[(w-1)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      key_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) key_o <= next_w;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_key_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(key_o));
  a_r7_top_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((key_o[127:96] ^ key_o[95:64]) == $past(key_i[127:96])));
  a_r4_round_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (rnd_w >= 4'd1 && rnd_w <= 4'd10 &&
                 (imm_i & 5'h07) == {2'b00, rnd_w[2:0]}));
  a_r5_rcon_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($onehot(rcon_w) || rcon_w == 8'h1b || rcon_w == 8'h36));
endmodule

// File: tb/tb_aes_ks_step.sv
`timescale 1ns/1ps
module tb_aes_ks_step;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [4:0]   imm_i = '0;
  logic         valid_o;
  logic [127:0] key_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  aes_ks_step dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .key_i(key_i), .imm_i(imm_i), .valid_o(valid_o), .key_o(key_o)
  );

  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= s;
      s = m_xt(s);
    end
    return r;
  endfunction
  function automatic logic [7:0] m_inv(input logic [7:0] x);
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction
  function automatic logic [7:0] m_sbox(input logic [7:0] x);
    logic [7:0] b, s;
    b = m_inv(x);
    s = 8'h63;
    for (int i = 0; i < 8; i++)
      s[i] = s[i] ^ b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return s;
  endfunction
  function automatic logic [127:0] m_next(input logic [127:0] k, input logic [4:0] imm);
    logic [7:0] rc [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h1b, 8'h36};
    int n, r;
    logic [31:0] w3, t;
    logic [31:0] nw [4];
    n = int'(imm[3:0]);
    r = (n >= 1 && n <= 10) ? n : (n ^ 8);
    w3 = k[127:96];
    w3 = {w3[7:0], w3[31:8]};
    for (int b = 0; b < 4; b++) t[b*8 +: 8] = m_sbox(w3[b*8 +: 8]);
    t[7:0] ^= rc[r-1];
    nw[0] = k[31:0] ^ t;
    for (int i = 1; i < 4; i++) nw[i] = k[i*32 +: 32] ^ nw[i-1];
    return {nw[3], nw[2], nw[1], nw[0]};
  endfunction
  // published hex order (first byte leftmost) -> lane order
  function automatic logic [127:0] to_lanes(input logic [127:0] h);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = h[127-8*i -: 8];
    return o;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [127:0] k, input logic [4:0] imm);
    @(negedge clk);
    valid_i = 1'b1; key_i = k; imm_i = imm;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] k, prev;
    logic [127:0] seeds [3];
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {127'b0, valid_o}, 128'd0);
    chk("R1 key in reset", key_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 idle valid", {127'b0, valid_o}, 128'd0);

    // zero key, round 1: each word 63636362
    step('0, 5'd1);
    chk("R2 valid after step", {127'b0, valid_o}, 128'd1);
    chk("R6 R5 zero key round 1", key_o, {4{32'h63636362}});
    @(negedge clk);
    chk("R2 valid one cycle", {127'b0, valid_o}, 128'd0);

    // full schedule from the published test key
    k = to_lanes(128'h2b7e151628aed2a6abf7158809cf4f3c);
    for (int r = 1; r <= 10; r++) begin
      step(k, 5'(r));
      chk($sformatf("R7 schedule round %0d", r), key_o, m_next(k, 5'(r)));
      if (r == 1) chk("R7 published round 1", key_o, to_lanes(128'ha0fafe1788542cb123a339392a6c7605));
      if (r == 2) chk("R7 published round 2", key_o, to_lanes(128'hf2c295f27a96b9435935807a7359f67f));
      if (r == 10) chk("R7 published round 10", key_o, to_lanes(128'hd014f9a8c9ee2589e13f0cc8b6630ca6));
      k = key_o;
    end

    // sweep every immediate over several keys
    seeds[0] = 128'h0123456789abcdeffedcba9876543210;
    seeds[1] = {4{32'hdeadbeef}};
    seeds[2] = 128'hffffffff00000000a5a5a5a55a5a5a5a;
    for (int s = 0; s < 3; s++)
      for (int i = 0; i < 32; i++) begin
        step(seeds[s], 5'(i));
        chk($sformatf("R3 R4 R5 imm %0d seed %0d", i, s), key_o, m_next(seeds[s], 5'(i)));
      end

    // fold pairs without the model
    step(seeds[0], 5'd8);  prev = key_o;
    step(seeds[0], 5'd0);  chk("R4 imm 0 acts as 8", key_o, prev);
    step(seeds[0], 5'd3);  prev = key_o;
    step(seeds[0], 5'd11); chk("R4 imm 11 acts as 3", key_o, prev);
    step(seeds[0], 5'd7);  prev = key_o;
    step(seeds[0], 5'd15); chk("R4 imm 15 acts as 7", key_o, prev);
    step(seeds[1], 5'd22); chk("R3 imm bit4 ignored", key_o, m_next(seeds[1], 5'd6));

    // hold while idle
    prev = key_o;
    @(negedge clk);
    key_i = ~key_i; imm_i = 5'd9;
    repeat (3) @(negedge clk);
    chk("R8 key held", key_o, prev);
    chk("R2 R8 valid low while idle", {127'b0, valid_o}, 128'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule